// File: doc/BRIEF.md
# Host Port with Pixel Monitor

This block is the parallel host interface of a video encoder. A host reaches an internal bank of 8-bit control registers through an address pointer. It uses an active-low chip select, a read/write strobe and an address select line. Data travels on one 8-bit bidirectional bus. All host controls are brought into the master clock domain through a two-flop synchroniser. Each transfer takes effect when the synchronised chip select is seen to fall.

The same bus has a diagnostic use. When the test register holds its unlock value and the pointer names one of two monitor addresses, a read no longer returns a stored byte. The port then streams the upper eight bits of an internal pixel tap, with a new value on every master clock: the composite output tap for one address and the luminance tap for the other. Raising chip select stops the stream and releases the bus. A hardware reset clears one soft-reset bit in the global control register and leaves all other control register contents alone.

Top module: `mpu_port_mon`

## Requirements
- R1: At a synchronised falling edge of `cs_n` with `rd_wr` low, the byte on `data_io` is stored. With `sel_ptr` high it goes into the pointer. With `sel_ptr` low it goes into the register the pointer names, and nothing is stored when the pointer is 16 or above.
- R2: At a synchronised falling edge of `cs_n` with `rd_wr` high, the port drives the bus. With `sel_ptr` high it returns the pointer. With `sel_ptr` low it returns the addressed register, or 0x00 for a pointer of 16 or above. Control inputs act two clock edges after they change.
- R3: `data_io` is high impedance whenever the synchronised `cs_n` is high, and during a write.
- R4: Register 15 is the test register and register 0 is the global control register; their storage and read-back follow R1 and R2 like any other register.
- R5: When register 15 equals 0x28 and the pointer equals 0x40, a read drives `comp_tap`, registered once, with a new sample on every clock.
- R6: When register 15 equals 0x28 and the pointer equals 0x60, a read drives `luma_tap` in the same way as R5.
- R7: Raising `cs_n` during a monitor stream ends it, and the bus returns to high impedance once the rise has passed the synchroniser.
- R8: While `rst_n` is low at a clock edge, bit 4 of register 0 is cleared and the pointer is set to 0x00. All other register bits keep their values.
- R9: With any other pointer value, or with register 15 not equal to 0x28, a read returns the normal contents described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Hardware reset, active low, sampled on clk |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_wr | input | 1 | 1 = read, 0 = write |
| sel_ptr | input | 1 | 1 = pointer access, 0 = register access |
| data_io | inout | 8 | Bidirectional data bus |
| comp_tap | input | 8 | Upper bits of the composite pixel stream |
| luma_tap | input | 8 | Upper bits of the luminance stream |

## Verification
The bench targets the monitor unlock, where the test value and the pointer value are each present with the other missing. A design that tests only one of them would stream pixels where a plain 0x00 is due. It drives taps that change on every clock. A design with a missing or extra stage on the monitor path, or one that latches a single sample, would show a shifted or frozen sequence. It also pulses reset after filling register 0 with 0xFF and reads back 0xEF and the test register. A reset that is too broad would lose the other bits, and one that is too narrow would leave bit 4 set. A port that drives the bus during writes or while deselected would corrupt the sentinel byte the bench keeps on the bus.

// File: rtl/mpu_port_mon.sv
module mpu_port_mon #(
  parameter int DW = 8,
  parameter int NREG = 16,
  parameter int GCTL_ADDR = 0,
  parameter int SRST_BIT = 4,
  parameter int TEST_ADDR = 15,
  parameter logic [DW-1:0] MON_KEY = 8'h28,
  parameter logic [DW-1:0] PTR_COMP = 8'h40,
  parameter logic [DW-1:0] PTR_LUMA = 8'h60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_wr,
  input  logic          sel_ptr,
  inout  wire  [DW-1:0] data_io,
  input  logic [DW-1:0] comp_tap,
  input  logic [DW-1:0] luma_tap
);
  localparam int AW = $clog2(NREG);
  localparam logic [DW-1:0] NREG_W = DW'(NREG);
  localparam logic [AW-1:0] GA = AW'(GCTL_ADDR);
  localparam logic [AW-1:0] TA = AW'(TEST_ADDR);

  logic [2:0]    cs_sh;
  logic [1:0]    rw_sh, sel_sh;
  logic [DW-1:0] ptr, mon_q, dout;
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_sh  <= '1;
      rw_sh  <= '0;
      sel_sh <= '0;
    end else begin
      cs_sh  <= {cs_sh[1:0], cs_n};
      rw_sh  <= {rw_sh[0], rd_wr};
      sel_sh <= {sel_sh[0], sel_ptr};
    end
  end

  wire cs_fall = cs_sh[2] & ~cs_sh[1];
  wire wr_go   = cs_fall & ~rw_sh[1];
  wire oe      = ~cs_sh[1] & rw_sh[1];
  wire addr_ok = ptr < NREG_W;
  wire mon_c   = (regs[TA] == MON_KEY) && (ptr == PTR_COMP);
  wire mon_l   = (regs[TA] == MON_KEY) && (ptr == PTR_LUMA);

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr <= '0;
    else if (wr_go && sel_sh[1]) ptr <= data_io;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      regs[GA][SRST_BIT] <= 1'b0;
    else if (wr_go && !sel_sh[1] && addr_ok)
      regs[ptr[AW-1:0]] <= data_io;
  end

  always_ff @(posedge clk)
    if (rst_n && !cs_sh[0] && (mon_c || mon_l))
      mon_q <= mon_c ? comp_tap : luma_tap;

  always_comb begin
    if (sel_sh[1])          dout = ptr;
    else if (mon_c || mon_l) dout = mon_q;
    else if (addr_ok)       dout = regs[ptr[AW-1:0]];
    else                    dout = '0;
  end

  assign data_io = oe ? dout : 'z;

  p_hiz_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> !oe);

  p_ptr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !rw_sh[1] && sel_sh[1]) |=> ptr == $past(data_io));

  p_mon_comp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_c && !cs_sh[0]) |=> mon_q == $past(comp_tap));

  p_mon_luma_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_l && !cs_sh[0]) |=> mon_q == $past(luma_tap));

  p_srst_clear_r8: assert property (@(posedge clk)
    !rst_n |=> !regs[GA][SRST_BIT]);

  p_test_kept_r8: assert property (@(posedge clk)
    !rst_n |=> $stable(regs[TA]));
endmodule

// File: tb/mpu_port_mon_tb_top.sv
`timescale 1ns/1ps
module mpu_port_mon_tb_top;
  localparam logic [7:0] SENT = 8'h5A;
  logic clk = 0, rst_n = 0, cs_n = 1, rd_wr = 0, sel_ptr = 0;
  logic tb_oe = 1;
  logic [7:0] tb_drv = SENT, comp_tap = 8'h01, luma_tap = 8'h80;
  wire  [7:0] bus;
  int checks = 0, errors = 0;
  bit finished = 0;
  string phase = "R1";

  assign bus = tb_oe ? tb_drv : 'z;
  always #2.5 clk = ~clk;

  mpu_port_mon dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr),
    .sel_ptr(sel_ptr), .data_io(bus), .comp_tap(comp_tap), .luma_tap(luma_tap));

  always @(negedge clk) begin
    comp_tap <= comp_tap + 8'd7;
    luma_tap <= luma_tap + 8'd13;
  end

  // behavioural reference model
  logic [7:0] m_reg [16];
  logic [7:0] m_ptr = 0, m_mq = 0;
  bit m_cs [3] = '{1, 1, 1};
  bit m_rw [3] = '{0, 0, 0};
  bit m_sel[3] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin m_cs[k] = 1; m_rw[k] = 0; m_sel[k] = 0; end
      m_ptr = 0;
      m_reg[0][4] = 0;
    end else begin
      if (!m_cs[0] && m_reg[15] == 8'h28 && m_ptr == 8'h40) m_mq = comp_tap;
      else if (!m_cs[0] && m_reg[15] == 8'h28 && m_ptr == 8'h60) m_mq = luma_tap;
      if (m_cs[2] && !m_cs[1] && !m_rw[1]) begin
        if (m_sel[1]) m_ptr = bus;
        else if (m_ptr < 16) m_reg[m_ptr[3:0]] = bus;
      end
      m_cs[2] = m_cs[1];   m_cs[1] = m_cs[0];   m_cs[0] = cs_n;
      m_rw[2] = m_rw[1];   m_rw[1] = m_rw[0];   m_rw[0] = rd_wr;
      m_sel[2] = m_sel[1]; m_sel[1] = m_sel[0]; m_sel[0] = sel_ptr;
    end
  end

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s (%s) got %h expected %h at %0t", tag, phase, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (tb_oe) check(bus, tb_drv, "R3 bus released");
      else if (!m_cs[1] && m_rw[1]) begin
        if (m_sel[1]) check(bus, m_ptr, "R2 pointer readback");
        else if (m_reg[15] == 8'h28 && m_ptr == 8'h40) check(bus, m_mq, "R5 composite stream");
        else if (m_reg[15] == 8'h28 && m_ptr == 8'h60) check(bus, m_mq, "R6 luma stream");
        else if (m_ptr < 16) check(bus, m_reg[m_ptr[3:0]], "R2 register read");
        else check(bus, 8'h00, "R9 unmapped read");
      end
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    tb_drv = d; cs_n = 0; rd_wr = 0; sel_ptr = sel;
    repeat (3) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
    tb_drv = SENT;
  endtask

  task automatic rd(input bit sel, input int n);
    @(negedge clk);
    tb_oe = 0; cs_n = 0; rd_wr = 1; sel_ptr = sel;
    repeat (n) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
    tb_oe = 1; tb_drv = SENT;
  endtask

  task automatic rd_expect(input logic [7:0] exp, input string tag);
    @(negedge clk);
    tb_oe = 0; cs_n = 0; rd_wr = 1; sel_ptr = 0;
    repeat (3) @(negedge clk);
    check(bus, exp, tag);
    cs_n = 1;
    repeat (3) @(negedge clk);
    tb_oe = 1; tb_drv = SENT;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    for (int i = 0; i < 16; i++) begin
      wr(1, 8'(i));
      wr(0, 8'(i * 19 + 7));
    end
    phase = "R2";
    wr(1, 8'd5);  rd(0, 6);
    rd(1, 5);
    wr(1, 8'd15); rd_expect(8'h24, "R4 test register read");
    phase = "R9";
    wr(1, 8'h20); wr(0, 8'hAA); rd(0, 5);
    wr(1, 8'h40); rd_expect(8'h00, "R9 no unlock");
    phase = "R5";
    wr(1, 8'd15); wr(0, 8'h28);
    wr(1, 8'h40); rd(0, 12);
    phase = "R7";
    rd(1, 4);
    phase = "R6";
    wr(1, 8'h60); rd(0, 12);
    phase = "R9";
    wr(1, 8'h41); rd(0, 5);
    wr(1, 8'h5F); rd_expect(8'h00, "R9 near miss pointer");
    phase = "R8";
    wr(1, 8'd0); wr(0, 8'hFF);
    wr(1, 8'd3);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rd_expect(8'hEF, "R8 srst bit cleared");
    wr(1, 8'd15); rd_expect(8'h28, "R8 test register kept");
    wr(1, 8'd3);  rd_expect(8'd64, "R8 register 3 kept");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule